// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block turns single host requests into one bus cycle on an 8-bit asynchronous NAND flash port. A host asks for a command byte, an address byte, a data byte write or a data byte read. The block then drives chip enable, the command and address latch enables, the write and read strobes and the data bus. Each cycle has three phases: setup, strobe and hold. The length of each phase comes from a 32-bit timing word, with separate values for read cycles and write cycles. When a cycle finishes, the ready flag is held off for a programmable number of clock pairs. After that the flag follows the device's synchronized ready/busy pin.

The host can hold chip enable low between cycles by setting a force bit. This keeps the device selected across a sequence of several cycles. A software reset pulse aborts any cycle in progress and clears both the timing word and the force bit. Sequencing above single bus cycles, DMA and error correction are left to other blocks.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset the bus is idle: nand_ce_n=1, nand_we_n=1, nand_re_n=1, nand_cle=0, nand_ale=0, nand_dq_oe=0, busy=0. The timing word and the force bit read back as 0, and dev_ready is 0 until the pin has passed through the synchronizer.
- R2: For write-type requests, the timing word fields are: bits [19:16] setup, [27:24] strobe width, [23:20] hold. A field value v gives v+1 clocks, so each phase lasts 1 to 16 clocks. nand_we_n is low only during the strobe phase.
- R3: For reads (req_op=3), the timing word fields are: bits [3:0] setup, [11:8] strobe width, [7:4] hold. A field value v gives v+1 clocks. nand_re_n is low only during the strobe phase.
- R4: req_op encodes the cycle type: 0 is command, 1 is address, 2 is data write, 3 is data read. nand_cle is high for every busy clock of a command cycle and for no other cycle. nand_ale does the same for address cycles.
- R5: On command, address and data-write cycles, nand_dq_oe is high and nand_dq_o holds req_data for the whole busy period. On read cycles nand_dq_oe stays 0.
- R6: A read captures nand_dq_i on the last clock of the read strobe. rd_data then holds that byte, and rd_valid pulses for exactly one clock at the start of the hold phase.
- R7: busy rises on the clock after a request is accepted and falls when the hold phase ends. A request presented while busy is ignored: the cycle length and the bus contents are unchanged, and no extra cycle follows.
- R8: nand_ce_n is low during every busy clock. It is also low whenever the force bit written through ce_wr/ce_val is set, and high when the bus is idle and the force bit is clear.
- R9: When a cycle ends, dev_ready is held at 0 for 2*n clocks. For a write-type cycle n is timing bits [31:28]; for a read cycle n is bits [15:12]. n=0 adds no wait.
- R10: Outside that wait, dev_ready follows nand_rb (1 = ready) through a two-flop synchronizer. A change on the pin is visible after exactly two clock edges.
- R11: A soft_rst pulse returns the block to idle on the next clock, with all strobes released. It also clears the timing word and the force bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software reset pulse: abort cycle, clear configuration |
| tim_wr | input | 1 | Load the timing word |
| tim_wdata | input | 32 | New timing word |
| tim_rdata | output | 32 | Current timing word |
| ce_wr | input | 1 | Load the chip-enable force bit |
| ce_val | input | 1 | New force bit value |
| ce_hold | output | 1 | Current force bit |
| req_valid | input | 1 | Request strobe, one clock |
| req_op | input | 2 | Cycle type: 0 command, 1 address, 2 data write, 3 data read |
| req_data | input | 8 | Byte to drive for command, address and write cycles |
| busy | output | 1 | Cycle in progress |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-clock pulse when rd_data updates |
| dev_ready | output | 1 | Synchronized ready flag, held at 0 during the ready wait |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The bench measures every phase length from the pins and checks it at both ends of the field range, 1 and 16 clocks. A counter that is off by one, or a field taken from the wrong nibble, shows up as a wrong count. For reads, the bench changes the input byte on every strobe clock. A design that latches early or late therefore returns a different byte. A second request is injected mid-cycle, and a soft reset is pulsed mid-cycle. A block that restarts its sequence or keeps running would show a longer busy period, a changed bus value, or nonzero configuration. The ready wait is timed separately for read and write cycles, so selecting the wrong nibble, or counting single clocks instead of pairs, gives the wrong count.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int FIELD_W = 4;
    localparam int TIM_W   = 8 * FIELD_W;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WDATA = 2'd2,
        OP_RDATA = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Packed MSB first; the bit layout is what the host writes.
    typedef struct packed {
        logic [FIELD_W-1:0] w_rdy;
        logic [FIELD_W-1:0] w_width;
        logic [FIELD_W-1:0] w_hold;
        logic [FIELD_W-1:0] w_setup;
        logic [FIELD_W-1:0] r_rdy;
        logic [FIELD_W-1:0] r_width;
        logic [FIELD_W-1:0] r_hold;
        logic [FIELD_W-1:0] r_setup;
    } timing_t;

    // Timing of one cycle, already resolved for its direction.
    typedef struct packed {
        logic [FIELD_W-1:0] setup;
        logic [FIELD_W-1:0] width;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] rdy;
    } cyc_timing_t;

    function automatic cyc_timing_t pick_dir(timing_t t, logic is_read);
        cyc_timing_t c;
        if (is_read) begin
            c.setup = t.r_setup;
            c.width = t.r_width;
            c.hold  = t.r_hold;
            c.rdy   = t.r_rdy;
        end else begin
            c.setup = t.w_setup;
            c.width = t.w_width;
            c.hold  = t.w_hold;
            c.rdy   = t.w_rdy;
        end
        return c;
    endfunction

endpackage

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
    import nand_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             tim_wr,
    input  logic [TIM_W-1:0] tim_wdata,
    input  logic             ce_wr,
    input  logic             ce_val,
    output timing_t          timing,
    output logic             ce_force
);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            timing   <= '0;
            ce_force <= 1'b0;
        end else begin
            if (tim_wr)
                timing <= timing_t'(tim_wdata);
            if (ce_wr)
                ce_force <= ce_val;
        end
    end

endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
    import nand_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  timing_t            timing,
    input  logic               req_valid,
    input  op_e                req_op,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [DATA_W-1:0]  dq_i,
    output phase_e             phase,
    output op_e                op_q,
    output logic [DATA_W-1:0]  data_q,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               end_now,
    output logic [FIELD_W-1:0] end_wait
);

    logic [FIELD_W-1:0] cnt;
    cyc_timing_t        cyc_t;
    cyc_timing_t        req_t;
    logic               cnt_zero;

    always_comb begin
        req_t    = pick_dir(timing, req_op == OP_RDATA);
        cnt_zero = (cnt == '0);
        end_now  = (phase == PH_HOLD) && cnt_zero;
        end_wait = cyc_t.rdy;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            op_q     <= OP_CMD;
            data_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            cyc_t    <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cyc_t  <= req_t;
                        cnt    <= req_t.setup;
                        op_q   <= req_op;
                        data_q <= req_data;
                        phase  <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase <= PH_STROBE;
                        cnt   <= cyc_t.width;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt_zero) begin
                        phase <= PH_HOLD;
                        cnt   <= cyc_t.hold;
                        if (op_q == OP_RDATA) begin
                            rd_data  <= dq_i;
                            rd_valid <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt_zero)
                        phase <= PH_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/nand_rdy_mon.sv
module nand_rdy_mon
    import nand_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               rb_pin,
    input  logic               end_now,
    input  logic [FIELD_W-1:0] end_wait,
    output logic               ready
);

    localparam int BLANK_W = FIELD_W + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [BLANK_W-1:0]     blank_cnt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= rb_pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], rb_pin};
            end
        end
    endgenerate

    // Wait is counted in clock pairs: load twice the field value.
    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            blank_cnt <= '0;
        else if (end_now)
            blank_cnt <= {end_wait, 1'b0};
        else if (blank_cnt != '0)
            blank_cnt <= blank_cnt - 1'b1;
    end

    assign ready = sync_q[SYNC_STAGES-1] && (blank_cnt == '0);

endmodule

// File: rtl/nand_pin_drive.sv
module nand_pin_drive
    import nand_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  phase_e             phase,
    input  op_e                op_q,
    input  logic [DATA_W-1:0]  data_q,
    input  logic               ce_force,
    output logic               busy,
    output logic               ce_n,
    output logic               cle,
    output logic               ale,
    output logic               we_n,
    output logic               re_n,
    output logic [DATA_W-1:0]  dq_o,
    output logic               dq_oe
);

    logic is_read;
    logic strobe;

    always_comb begin
        busy    = (phase != PH_IDLE);
        is_read = (op_q == OP_RDATA);
        strobe  = (phase == PH_STROBE);
        ce_n    = ~(ce_force | busy);
        cle     = busy && (op_q == OP_CMD);
        ale     = busy && (op_q == OP_ADDR);
        we_n    = ~(strobe && !is_read);
        re_n    = ~(strobe && is_read);
        dq_oe   = busy && !is_read;
        dq_o    = data_q;
    end

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
    import nand_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              tim_wr,
    input  logic [31:0]       tim_wdata,
    output logic [31:0]       tim_rdata,
    input  logic              ce_wr,
    input  logic              ce_val,
    output logic              ce_hold,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              dev_ready,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_i,
    input  logic              nand_rb
);

    timing_t            timing;
    logic               ce_force;
    phase_e             phase;
    op_e                op_q;
    logic [DATA_W-1:0]  data_q;
    logic               end_now;
    logic [FIELD_W-1:0] end_wait;

    nand_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .tim_wr    (tim_wr),
        .tim_wdata (tim_wdata),
        .ce_wr     (ce_wr),
        .ce_val    (ce_val),
        .timing    (timing),
        .ce_force  (ce_force)
    );

    nand_phase_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .timing    (timing),
        .req_valid (req_valid),
        .req_op    (op_e'(req_op)),
        .req_data  (req_data),
        .dq_i      (nand_dq_i),
        .phase     (phase),
        .op_q      (op_q),
        .data_q    (data_q),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .end_now   (end_now),
        .end_wait  (end_wait)
    );

    nand_rdy_mon #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .rb_pin   (nand_rb),
        .end_now  (end_now),
        .end_wait (end_wait),
        .ready    (dev_ready)
    );

    nand_pin_drive #(.DATA_W(DATA_W)) u_pins (
        .phase    (phase),
        .op_q     (op_q),
        .data_q   (data_q),
        .ce_force (ce_force),
        .busy     (busy),
        .ce_n     (nand_ce_n),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .dq_o     (nand_dq_o),
        .dq_oe    (nand_dq_oe)
    );

    assign tim_rdata = timing;
    assign ce_hold   = ce_force;

endmodule

// File: rtl/nand_strobe_seq_chk.sv
module nand_strobe_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              busy,
    input logic              rd_valid,
    input logic [31:0]       tim_rdata,
    input logic              ce_hold,
    input logic              nand_ce_n,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic              nand_dq_oe,
    input logic [DATA_W-1:0] nand_dq_o
);

    // R4: command and address latch enables never overlap
    a_r4_cle_ale_excl: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    // R2/R3: only one strobe at a time, and only inside a busy cycle
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    a_r7_strobe_in_busy: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> busy);

    // R8: chip enable asserted throughout any cycle
    a_r8_ce_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !nand_ce_n);

    // R5: bus not driven while the device drives it
    a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe);

    // R6: read-valid is a single pulse after the strobe is released
    a_r6_rdv_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r6_rdv_in_hold: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (busy && nand_re_n));

    // R7: a request during a cycle does not change the bus value
    a_r7_bus_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && !soft_rst) |=> $stable(nand_dq_o));

    // R11: soft reset idles the bus and clears configuration
    a_r11_soft_reset: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!busy && nand_we_n && nand_re_n && tim_rdata == 32'd0 && !ce_hold));

endmodule

bind nand_strobe_seq nand_strobe_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .tim_rdata  (tim_rdata),
    .ce_hold    (ce_hold),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .nand_dq_o  (nand_dq_o)
);

// File: tb/tb_nand_strobe_seq.sv
module tb_nand_strobe_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        tim_wr = 1'b0;
    logic [31:0] tim_wdata = '0;
    logic [31:0] tim_rdata;
    logic        ce_wr = 1'b0;
    logic        ce_val = 1'b0;
    logic        ce_hold;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [7:0]  req_data = '0;
    logic        busy;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        dev_ready;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rb = 1'b1;

    always #5 clk = ~clk;

    nand_strobe_seq dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .tim_wr(tim_wr), .tim_wdata(tim_wdata), .tim_rdata(tim_rdata),
        .ce_wr(ce_wr), .ce_val(ce_val), .ce_hold(ce_hold),
        .req_valid(req_valid), .req_op(req_op), .req_data(req_data),
        .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid), .dev_ready(dev_ready),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Vector: timing word, op, data, expected setup/width/hold clocks
    typedef struct packed {
        logic [31:0] tim;
        logic [1:0]  op;
        logic [7:0]  data;
        logic [4:0]  es;
        logic [4:0]  ew;
        logic [4:0]  eh;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 2'd0, 8'h70, 5'd1,  5'd1,  5'd1},
        '{32'h0213_0000, 2'd1, 8'h12, 5'd4,  5'd3,  5'd2},
        '{32'h0F0F_0000, 2'd2, 8'h5A, 5'd16, 5'd16, 5'd1},
        '{32'h0000_0312, 2'd3, 8'h00, 5'd3,  5'd4,  5'd2},
        '{32'h0000_0F00, 2'd3, 8'h00, 5'd1,  5'd16, 5'd1},
        '{32'h0000_00F0, 2'd3, 8'h00, 5'd1,  5'd1,  5'd16},
        '{32'hFFFF_0000, 2'd2, 8'hC3, 5'd16, 5'd16, 5'd16}
    };

    int m_setup, m_width, m_hold, m_total, m_cle, m_ale, m_oe, m_dqbad, m_cebad, m_rdv;

    task automatic write_timing(input logic [31:0] w);
        @(negedge clk); tim_wr = 1'b1; tim_wdata = w;
        @(negedge clk); tim_wr = 1'b0;
    endtask

    task automatic run_cycle(input logic [1:0] op, input logic [7:0] d, input int intrude_at);
        bit seen = 1'b0;
        m_setup = 0; m_width = 0; m_hold = 0; m_total = 0; m_cle = 0;
        m_ale = 0; m_oe = 0; m_dqbad = 0; m_cebad = 0; m_rdv = 0;
        @(negedge clk); req_valid = 1'b1; req_op = op; req_data = d;
        @(negedge clk); req_valid = 1'b0;
        for (int i = 0; i < 200 && busy; i++) begin
            m_total++;
            if (nand_cle) m_cle++;
            if (nand_ale) m_ale++;
            if (nand_dq_oe) m_oe++;
            if (nand_dq_oe && nand_dq_o !== d) m_dqbad++;
            if (nand_ce_n) m_cebad++;
            if (rd_valid) m_rdv++;
            if (!nand_we_n || !nand_re_n) begin
                if (!nand_re_n) nand_dq_i = 8'hA0 + 8'(m_width);
                m_width++;
                seen = 1'b1;
            end else if (!seen) m_setup++;
            else m_hold++;
            if (i == intrude_at) begin
                req_valid = 1'b1; req_op = 2'd0; req_data = 8'hEE;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !busy,
              "R1", "idle pins", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, busy}, 7'b1110000);
        check(tim_rdata == 0 && !ce_hold, "R1", "config cleared", tim_rdata, 0);
        check(!dev_ready, "R1", "ready before sync", dev_ready, 0);
        repeat (3) @(negedge clk);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            vec_t cv = VECS[v];
            bit rd = (cv.op == 2'd3);
            string rq = rd ? "R3" : "R2";
            write_timing(cv.tim);
            run_cycle(cv.op, cv.data, -1);
            check(m_setup == int'(cv.es), rq, $sformatf("v%0d setup", v), m_setup, cv.es);
            check(m_width == int'(cv.ew), rq, $sformatf("v%0d width", v), m_width, cv.ew);
            check(m_hold  == int'(cv.eh), rq, $sformatf("v%0d hold", v), m_hold, cv.eh);
            check(m_cle == ((cv.op == 2'd0) ? m_total : 0), "R4", $sformatf("v%0d cle", v), m_cle, m_total);
            check(m_ale == ((cv.op == 2'd1) ? m_total : 0), "R4", $sformatf("v%0d ale", v), m_ale, m_total);
            check(m_oe == (rd ? 0 : m_total), "R5", $sformatf("v%0d oe", v), m_oe, rd ? 0 : m_total);
            check(m_dqbad == 0, "R5", $sformatf("v%0d dq", v), m_dqbad, 0);
            check(m_cebad == 0, "R8", $sformatf("v%0d ce", v), m_cebad, 0);
            if (rd) begin
                check(rd_data == 8'hA0 + 8'(cv.ew - 1), "R6", $sformatf("v%0d latch", v), rd_data, 8'hA0 + 8'(cv.ew - 1));
                check(m_rdv == 1, "R6", $sformatf("v%0d rd_valid", v), m_rdv, 1);
            end
            repeat (40) @(negedge clk);
        end

        // R7: request during busy is ignored
        write_timing(32'h0333_0000);
        run_cycle(2'd2, 8'h11, 3);
        check(m_total == 12, "R7", "busy length with intrusion", m_total, 12);
        check(m_cle == 0 && m_dqbad == 0, "R7", "bus untouched", m_cle + m_dqbad, 0);
        repeat (4) @(negedge clk);
        check(!busy, "R7", "no extra cycle", busy, 0);

        // R9: ready wait per direction
        write_timing(32'h3000_5000);
        repeat (4) @(negedge clk);
        run_cycle(2'd0, 8'hFF, -1);
        begin
            int c = 0;
            for (int i = 0; i < 100 && !dev_ready; i++) begin c++; @(negedge clk); end
            check(c == 6, "R9", "write ready wait", c, 6);
        end
        run_cycle(2'd3, 8'h00, -1);
        begin
            int c = 0;
            for (int i = 0; i < 100 && !dev_ready; i++) begin c++; @(negedge clk); end
            check(c == 10, "R9", "read ready wait", c, 10);
        end

        // R10: synchronizer latency
        nand_rb = 1'b0;
        @(negedge clk);
        check(dev_ready, "R10", "one edge after fall", dev_ready, 1);
        @(negedge clk);
        check(!dev_ready, "R10", "two edges after fall", dev_ready, 0);
        nand_rb = 1'b1;
        repeat (2) @(negedge clk);
        check(dev_ready, "R10", "two edges after rise", dev_ready, 1);

        // R8: chip-enable force bit
        @(negedge clk); ce_wr = 1'b1; ce_val = 1'b1;
        @(negedge clk); ce_wr = 1'b0;
        check(!nand_ce_n && ce_hold, "R8", "forced low idle", nand_ce_n, 0);
        @(negedge clk); ce_wr = 1'b1; ce_val = 1'b0;
        @(negedge clk); ce_wr = 1'b0;
        check(nand_ce_n, "R8", "released idle", nand_ce_n, 1);

        // R11: soft reset mid-cycle
        write_timing(32'h0555_0000);
        @(negedge clk); ce_wr = 1'b1; ce_val = 1'b1;
        @(negedge clk); ce_wr = 1'b0;
        req_valid = 1'b1; req_op = 2'd2; req_data = 8'h3C;
        @(negedge clk); req_valid = 1'b0;
        repeat (8) @(negedge clk);
        check(busy && !nand_we_n, "R11", "in strobe before reset", busy, 1);
        soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        check(!busy && nand_we_n && nand_re_n && !nand_dq_oe, "R11", "idle after soft reset", busy, 0);
        check(tim_rdata == 0 && !ce_hold && nand_ce_n, "R11", "config cleared", tim_rdata, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule